// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Sequencer

This block sits beside the control unit of a small 8-bit processor and decides when an interrupt is taken. It looks at the pending requests only when the core reports that an instruction has finished. A request counts only when the global mask bit is clear and the source's own enable is set. When several requests qualify, the one with the lowest index wins. The sequencer then writes the saved context to the stack one byte per cycle, walking downwards through memory. After the condition-code byte is written it sets the mask. In the next cycle it presents a vector fetch together with a one-cycle acknowledge to the chosen source.

When the core decodes a return-from-interrupt, the sequencer reads the five saved bytes back in reverse order. It restores the mask from the saved condition-code byte and hands the restored registers back to the core. If a qualified request is pending when the last byte has been read, no resume is issued. Instead the sequencer flags the core's prefetched opcode as discarded and starts a new entry at once, saving the same background context again. The high index byte is never saved, so software must save it if a service routine uses it.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is recognised only in the cycle where `insn_done` is high while the sequencer is idle. Requests that are held pending with `insn_done` low start no stack activity.
- R2: A request qualifies only when the mask bit (`mask_o`, bit 3 of the condition-code byte) is 0 and its bit in `irq_en` is 1. A boundary with no qualified request leaves `busy`, `sp_o` and the stack untouched.
- R3: Among the qualified requests, the lowest bit index is serviced first.
- R4: Entry writes five bytes at descending addresses starting at `sp_o`, in this order: low byte of `ret_pc`-1, high byte of `ret_pc`-1, X, A, and then the condition-code byte with bit 3 replaced by the mask value held before entry.
- R5: The high index byte is not stacked. Each entry makes exactly five stack writes.
- R6: The mask is set by the last push. The following cycle raises `vec_fetch` for one cycle, with `vec_idx` equal to the winner, `vec_addr` equal to VEC_TOP - 2*index, and `irq_ack` one-hot on the winner.
- R7: After reset `sp_o` is 0x00FF and the mask is 1. `sp_o` is decremented after each push. Before each pull it is incremented and that incremented address is read.
- R8: A return reads five bytes in reverse push order and loads the mask from bit 3 of the pulled condition-code byte. In its final cycle it raises `rti_done`, with `rest_pc` = pulled address + 1 and the pulled A, X and condition-code byte. It also raises `resume` when nothing is pending.
- R9: If a qualified request is pending when the return finishes, `prefetch_drop` is raised instead of `resume`. A new entry then writes the same five bytes back to the same addresses.
- R10: A request that arrives while the mask is set waits until a return clears the mask, and is then serviced.
- R11: `mask_set` and `mask_clr` pulses given while idle set and clear the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | Current instruction has completed |
| rti_start | input | 1 | Core decoded a return-from-interrupt |
| mask_set | input | 1 | Set the mask bit (idle only) |
| mask_clr | input | 1 | Clear the mask bit (idle only) |
| irq_pend | input | NSRC | Pending requests, bit 0 highest priority |
| irq_en | input | NSRC | Per-source enables |
| ret_pc | input | 16 | Address of next background instruction |
| x_in | input | 8 | Low index register |
| a_in | input | 8 | Accumulator |
| ccr_in | input | 8 | Condition-code byte from the core |
| rd_data | input | 8 | Stack read data, same cycle as address |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 16 | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| sp_o | output | 16 | Stack pointer |
| mask_o | output | 1 | Global mask bit |
| busy | output | 1 | Sequencer not idle |
| vec_fetch | output | 1 | Vector fetch cycle |
| vec_idx | output | 3 | Winning source index |
| vec_addr | output | 16 | Vector address |
| irq_ack | output | NSRC | One-hot acknowledge |
| rti_done | output | 1 | Return finished, restored values valid |
| resume | output | 1 | Execute prefetched opcode |
| prefetch_drop | output | 1 | Prefetched opcode discarded, chaining |
| rest_pc | output | 16 | Restored program counter |
| rest_a | output | 8 | Restored accumulator |
| rest_x | output | 8 | Restored index |
| rest_ccr | output | 8 | Restored condition-code byte |

## Verification
The bench builds the block with its defaults: eight sources, a reset stack pointer of 0x00FF and a vector top of 0xFFFC. With these values every priority position, including the lowest one at index 7, can be reached from a single request byte. The stack stays inside a 256-byte model, so each pushed byte can be read back by address. A chained return followed by a plain return is also covered, and so is the nested case where a second request arrives while the mask is set.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PUSH = 3'd1,
    ST_VEC  = 3'd2,
    ST_PULL = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_t;

  localparam int unsigned FRAME_BYTES = 5;
  localparam int unsigned MASK_BIT    = 3;

  // Replace the mask position of a condition-code byte with m.
  function automatic logic [7:0] ccr_with_mask(input logic [7:0] c, input logic m);
    logic [7:0] flip;
    flip = 8'd0;
    flip[MASK_BIT] = c[MASK_BIT] ^ m;
    return c ^ flip;
  endfunction

  // The stack holds the return address minus one.
  function automatic logic [15:0] pc_to_frame(input logic [15:0] pc);
    return pc - 16'd1;
  endfunction

  function automatic logic [15:0] frame_to_pc(input logic [15:0] v);
    return v + 16'd1;
  endfunction
endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NSRC = 8,
  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            masked,
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [NSRC-1:0] first
);
  logic [NSRC-1:0] qual;
  assign qual = req & en & {NSRC{~masked}};
  assign any  = |qual;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_first
      if (g == 0) begin : g_top
        assign first[g] = qual[g];
      end else begin : g_rest
        assign first[g] = qual[g] & ~(|qual[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end

  always_comb begin
    assert_single_winner_R3: assert ($onehot0(first) && (any == (|first)))
      else $error("priority winner not unique");
  end
endmodule

// File: rtl/irq_sp.sv
module irq_sp #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] SP_RST = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pull,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] sp_q;

  assign addr = pull ? (sp_q + AW'(1)) : sp_q;
  assign sp   = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= SP_RST;
    else if (push) sp_q <= sp_q - AW'(1);
    else if (pull) sp_q <= sp_q + AW'(1);
  end

  assert_push_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) - AW'(1));
  assert_pull_reads_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> sp_q == $past(addr));
  assert_no_push_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pull));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  parameter logic [15:0] SP_RST = 16'h00FF,
  parameter logic [15:0] VEC_TOP = 16'hFFFC,
  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int unsigned CW = $clog2(FRAME_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_done,
  input  logic            rti_start,
  input  logic            mask_set,
  input  logic            mask_clr,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic [15:0]     ret_pc,
  input  logic [7:0]      x_in,
  input  logic [7:0]      a_in,
  input  logic [7:0]      ccr_in,
  input  logic [7:0]      rd_data,
  output logic            stk_we,
  output logic            stk_re,
  output logic [15:0]     stk_addr,
  output logic [7:0]      stk_wdata,
  output logic [15:0]     sp_o,
  output logic            mask_o,
  output logic            busy,
  output logic            vec_fetch,
  output logic [IW-1:0]   vec_idx,
  output logic [15:0]     vec_addr,
  output logic [NSRC-1:0] irq_ack,
  output logic            rti_done,
  output logic            resume,
  output logic            prefetch_drop,
  output logic [15:0]     rest_pc,
  output logic [7:0]      rest_a,
  output logic [7:0]      rest_x,
  output logic [7:0]      rest_ccr
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BYTES - 1);

  function automatic logic [15:0] vector_of(input logic [IW-1:0] i);
    logic [15:0] off;
    off = 16'(i) << 1;
    return VEC_TOP - off;
  endfunction

  seq_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] win_q;
  logic [15:0]   ctx_pc_q;
  logic [7:0]    ctx_x_q, ctx_a_q, ctx_ccr_q;
  logic          mask_q;

  // named internal events
  logic            any_q;
  logic [IW-1:0]   pick_idx;
  logic [NSRC-1:0] pick_first;
  logic            take_now, chain_now, rti_now, push_ev, pull_ev, last_push;

  irq_prio #(.NSRC(NSRC)) u_prio (
    .req(irq_pend), .en(irq_en), .masked(mask_q),
    .any(any_q), .idx(pick_idx), .first(pick_first)
  );

  assign take_now  = (st_q == ST_IDLE) && insn_done && !rti_start && any_q;
  assign rti_now   = (st_q == ST_IDLE) && rti_start;
  assign chain_now = (st_q == ST_FIN) && any_q;
  assign push_ev   = (st_q == ST_PUSH);
  assign pull_ev   = (st_q == ST_PULL);
  assign last_push = push_ev && (cnt_q == LAST);

  irq_sp #(.AW(16), .SP_RST(SP_RST)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .pull(pull_ev),
    .sp(sp_o), .addr(stk_addr)
  );

  always_comb begin
    unique case (cnt_q)
      CW'(0):  stk_wdata = ctx_pc_q[7:0];
      CW'(1):  stk_wdata = ctx_pc_q[15:8];
      CW'(2):  stk_wdata = ctx_x_q;
      CW'(3):  stk_wdata = ctx_a_q;
      default: stk_wdata = ccr_with_mask(ctx_ccr_q, mask_q);
    endcase
  end

  assign stk_we        = push_ev;
  assign stk_re        = pull_ev;
  assign busy          = (st_q != ST_IDLE);
  assign mask_o        = mask_q;
  assign vec_fetch     = (st_q == ST_VEC);
  assign vec_idx       = win_q;
  assign vec_addr      = vector_of(win_q);
  assign rti_done      = (st_q == ST_FIN);
  assign resume        = rti_done && !any_q;
  assign prefetch_drop = chain_now;
  assign rest_pc       = frame_to_pc(ctx_pc_q);
  assign rest_a        = ctx_a_q;
  assign rest_x        = ctx_x_q;
  assign rest_ccr      = ctx_ccr_q;

  always_comb begin
    irq_ack = '0;
    if (vec_fetch) irq_ack[win_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      win_q     <= '0;
      ctx_pc_q  <= '0;
      ctx_x_q   <= '0;
      ctx_a_q   <= '0;
      ctx_ccr_q <= '0;
      mask_q    <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (rti_now) begin
            st_q <= ST_PULL;
          end else if (take_now) begin
            st_q      <= ST_PUSH;
            win_q     <= pick_idx;
            ctx_pc_q  <= pc_to_frame(ret_pc);
            ctx_x_q   <= x_in;
            ctx_a_q   <= a_in;
            ctx_ccr_q <= ccr_in;
          end else if (mask_set) begin
            mask_q <= 1'b1;
          end else if (mask_clr) begin
            mask_q <= 1'b0;
          end
        end
        ST_PUSH: begin
          if (last_push) begin
            mask_q <= 1'b1;
            st_q   <= ST_VEC;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_VEC: st_q <= ST_IDLE;
        ST_PULL: begin
          unique case (cnt_q)
            CW'(0): begin
              ctx_ccr_q <= rd_data;
              mask_q    <= rd_data[MASK_BIT];
            end
            CW'(1):  ctx_a_q <= rd_data;
            CW'(2):  ctx_x_q <= rd_data;
            CW'(3):  ctx_pc_q[15:8] <= rd_data;
            default: ctx_pc_q[7:0]  <= rd_data;
          endcase
          if (cnt_q == LAST) begin
            st_q  <= ST_FIN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_FIN: begin
          cnt_q <= '0;
          if (chain_now) begin
            st_q  <= ST_PUSH;
            win_q <= pick_idx;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_vec_after_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> mask_q);
  assert_vec_follows_last_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> $past(stk_we));
  assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack) && ((irq_ack != '0) == vec_fetch));
  assert_start_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(insn_done || rti_start));
  assert_no_rw_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re));
  assert_drop_excl_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(prefetch_drop && resume));
  assert_drop_starts_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_drop |=> stk_we);
  assert_mask_blocks_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mask_q && !rti_start) |=> !stk_we);
endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  logic clk = 0, rst_n = 0;
  logic insn_done = 0, rti_start = 0, mask_set = 0, mask_clr = 0;
  logic [NSRC-1:0] irq_pend = '0, irq_en = '0;
  logic [15:0] ret_pc = 16'h1234;
  logic [7:0]  x_in = 8'h5A, a_in = 8'hC3, ccr_in = 8'h6B;
  logic [7:0]  rd_data;
  logic stk_we, stk_re, mask_o, busy, vec_fetch, rti_done, resume, prefetch_drop;
  logic [15:0] stk_addr, sp_o, vec_addr, rest_pc;
  logic [7:0]  stk_wdata, rest_a, rest_x, rest_ccr;
  logic [2:0]  vec_idx;
  logic [NSRC-1:0] irq_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rti_start(rti_start),
    .mask_set(mask_set), .mask_clr(mask_clr), .irq_pend(irq_pend), .irq_en(irq_en),
    .ret_pc(ret_pc), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in), .rd_data(rd_data),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .sp_o(sp_o), .mask_o(mask_o), .busy(busy), .vec_fetch(vec_fetch),
    .vec_idx(vec_idx), .vec_addr(vec_addr), .irq_ack(irq_ack), .rti_done(rti_done),
    .resume(resume), .prefetch_drop(prefetch_drop), .rest_pc(rest_pc),
    .rest_a(rest_a), .rest_x(rest_x), .rest_ccr(rest_ccr)
  );

  logic [7:0] mem [0:255];
  assign rd_data = mem[stk_addr[7:0]];

  int n_wr = 0, n_vec = 0, n_done = 0, n_drop = 0, n_res = 0;
  logic [2:0]  seen_idx;
  logic [15:0] seen_vaddr, seen_pc;
  logic [7:0]  seen_ack, seen_a, seen_x, seen_ccr;

  always @(posedge clk) begin
    if (rst_n) begin
      if (stk_we) begin mem[stk_addr[7:0]] <= stk_wdata; n_wr <= n_wr + 1; end
      if (vec_fetch) begin
        n_vec <= n_vec + 1; seen_idx <= vec_idx; seen_vaddr <= vec_addr; seen_ack <= irq_ack;
      end
      if (rti_done) begin
        n_done <= n_done + 1; seen_pc <= rest_pc; seen_a <= rest_a;
        seen_x <= rest_x; seen_ccr <= rest_ccr;
        if (resume) n_res <= n_res + 1;
        if (prefetch_drop) n_drop <= n_drop + 1;
      end
    end
  end

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_counts();
    n_wr = 0; n_vec = 0; n_done = 0; n_drop = 0; n_res = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(); tick(); rst_n = 1; clear_counts();
  endtask

  task automatic pulse_clr();
    mask_clr = 1; tick(); mask_clr = 0;
  endtask

  task automatic boundary();
    insn_done = 1; tick(); insn_done = 0; repeat (8) tick();
  endtask

  task automatic do_rti();
    rti_start = 1; tick(); rti_start = 0; repeat (14) tick();
  endtask

  function automatic logic [15:0] exp_vec(input int i);
    return 16'hFFFC - 16'(2 * i);
  endfunction

  // {pend, en, mask, take, idx}
  localparam logic [20:0] TBL [8] = '{
    {8'h01, 8'hFF, 1'b0, 1'b1, 3'd0},
    {8'h90, 8'hFF, 1'b0, 1'b1, 3'd4},
    {8'h90, 8'h80, 1'b0, 1'b1, 3'd7},
    {8'hFF, 8'hFF, 1'b1, 1'b0, 3'd0},
    {8'h0F, 8'hF0, 1'b0, 1'b0, 3'd0},
    {8'h06, 8'h04, 1'b0, 1'b1, 3'd2},
    {8'h00, 8'hFF, 1'b0, 1'b0, 3'd0},
    {8'h80, 8'hFF, 1'b0, 1'b1, 3'd7}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    do_reset();
    // R7 reset state
    chk(sp_o == 16'h00FF, "R7 reset sp", sp_o, 16'h00FF);
    chk(mask_o == 1'b1, "R7 reset mask", mask_o, 1);
    chk(busy == 1'b0 && irq_ack == '0, "R7 reset idle", busy, 0);

    // Table walk: R2 gating, R3 priority, R5, R6
    for (int r = 0; r < 8; r++) begin
      logic [20:0] row;
      row = TBL[r];
      do_reset();
      if (!row[4]) pulse_clr();
      irq_pend = row[20:13]; irq_en = row[12:5];
      clear_counts();
      boundary();
      if (row[3]) begin
        chk(n_vec == 1, "R2 entry taken", n_vec, 1);
        chk(seen_idx == row[2:0], "R3 winner", seen_idx, row[2:0]);
        chk(seen_vaddr == exp_vec(int'(row[2:0])), "R6 vector addr", seen_vaddr, exp_vec(int'(row[2:0])));
        chk(seen_ack == (8'h01 << row[2:0]), "R6 ack", seen_ack, 8'h01 << row[2:0]);
        chk(n_wr == 5, "R5 five writes", n_wr, 5);
        chk(mask_o == 1'b1, "R6 mask set", mask_o, 1);
        chk(sp_o == 16'h00FA, "R7 sp after entry", sp_o, 16'h00FA);
      end else begin
        chk(n_vec == 0 && n_wr == 0, "R2 no entry", n_wr, 0);
        chk(sp_o == 16'h00FF && !busy, "R2 sp untouched", sp_o, 16'h00FF);
      end
      irq_pend = '0;
    end

    // R1: pending held without boundary
    do_reset(); pulse_clr();
    irq_pend = 8'h01; irq_en = 8'hFF; clear_counts();
    repeat (10) tick();
    chk(n_wr == 0 && n_vec == 0 && !busy, "R1 no entry without boundary", n_wr, 0);
    // R11: mask_set then boundary blocked; mask_clr then taken
    mask_set = 1; tick(); mask_set = 0;
    chk(mask_o == 1'b1, "R11 mask set", mask_o, 1);
    boundary();
    chk(n_vec == 0, "R11 masked boundary", n_vec, 0);
    pulse_clr();
    chk(mask_o == 1'b0, "R11 mask cleared", mask_o, 0);
    irq_pend = '0;

    // R4/R8/R9/R10 nested and chained
    do_reset(); pulse_clr();
    irq_en = 8'hFF; irq_pend = 8'h04; clear_counts();
    boundary();
    chk(seen_idx == 3'd2, "R3 first service", seen_idx, 2);
    chk(mem[8'hFF] == 8'h33, "R4 pc low", mem[8'hFF], 8'h33);
    chk(mem[8'hFE] == 8'h12, "R4 pc high", mem[8'hFE], 8'h12);
    chk(mem[8'hFD] == 8'h5A, "R4 x byte", mem[8'hFD], 8'h5A);
    chk(mem[8'hFC] == 8'hC3, "R4 a byte", mem[8'hFC], 8'hC3);
    chk(mem[8'hFB] == 8'h63, "R4 ccr byte", mem[8'hFB], 8'h63);
    chk(mem[8'hFA] == 8'h00, "R5 no fifth-below write", mem[8'hFA], 0);
    irq_pend = 8'h01; // arrives while mask set
    clear_counts();
    boundary();
    chk(n_vec == 0 && n_wr == 0, "R10 held while masked", n_wr, 0);
    for (int i = 0; i < 256; i++) if (i < 8'hFB) mem[i] = 8'hEE;
    clear_counts();
    do_rti();
    chk(n_done == 1 && n_drop == 1 && n_res == 0, "R9 chain drop", n_drop, 1);
    chk(n_vec == 1 && seen_idx == 3'd0, "R10 second serviced", seen_idx, 0);
    chk(n_wr == 5 && mem[8'hFF] == 8'h33 && mem[8'hFB] == 8'h63, "R9 same frame", mem[8'hFB], 8'h63);
    chk(sp_o == 16'h00FA, "R9 sp after chain", sp_o, 16'h00FA);
    irq_pend = '0; clear_counts();
    do_rti();
    chk(n_done == 1 && n_res == 1 && n_drop == 0, "R8 resume", n_res, 1);
    chk(seen_pc == 16'h1234, "R8 restored pc", seen_pc, 16'h1234);
    chk(seen_a == 8'hC3 && seen_x == 8'h5A, "R8 restored a/x", {seen_a, seen_x}, 16'hC35A);
    chk(seen_ccr == 8'h63, "R8 restored ccr", seen_ccr, 8'h63);
    chk(mask_o == 1'b0, "R8 mask restored", mask_o, 0);
    chk(sp_o == 16'h00FF, "R7 sp after pulls", sp_o, 16'h00FF);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule